// File: doc/BRIEF.md
# Memory-Class Aware Line Cache with Maintenance Sweeps

This block models a small direct-mapped cache in which each line is one data word and carries a two-bit memory class that comes with every access. The class selects the policy for that line. Local read-write and remote non-coherent data are held write-back. Local coherent data is written through to memory. Uncached data never enters the array. One request channel carries reads, writes and the two maintenance commands. Because the channel is strictly in order, a maintenance command can never pass an earlier access or be passed by a later one.

The writeback-all command sweeps the array and flushes every dirty line. The invalidate-all command drops only the remote non-coherent lines, which are the only lines that can go stale without notice. A probe port reports writes made by other agents. A probe that hits a local-class line removes that line, and a dirty line is flushed before it is removed. A memory port with a valid/ready handshake carries fills, write-throughs and writebacks. Reads return their data one or more cycles after the handshake.

Top module: `mtc_cache_top`

## Requirements
- R1: After reset every line is invalid, `req_ready` and `probe_ready` are high, and `rsp_valid`, `mnt_done` and `mem_req_valid` are low.
- R2: The command codes on `req_cmd` are 0 read, 1 write, 2 writeback-all and 3 invalidate-all. A read that misses in a cacheable class issues one memory read and returns its data. A repeat read of the same address then hits and returns the same data with no memory traffic.
- R3: The class codes on `req_mtype` are 0 local read-write, 1 local coherent, 2 remote non-coherent and 3 uncached. Uncached reads and writes go to memory every time and never allocate a line.
- R4: A write in the local coherent class (1) updates or allocates the line clean and issues one memory write of the same data before `rsp_valid`. Such a line is never written back by a later writeback-all.
- R5: A write in class 0 or 2 updates or allocates the line dirty with no memory traffic. A later access that maps to the same index with another tag first writes the dirty victim back at its own address.
- R6: Writeback-all writes each dirty line back exactly once, with its address and data, and leaves the line valid and clean. A second writeback-all with no writes in between issues no memory traffic.
- R7: Invalidate-all removes class 2 lines only. A later read of such an address refetches from memory. Class 0 and class 1 lines still hit.
- R8: A probe that hits a class 0 or class 1 line invalidates it, after first writing it back if it is dirty. A probe that hits a class 2 line, or that matches the index but not the tag, changes nothing.
- R9: From the cycle after a maintenance command is accepted until `mnt_done`, `req_ready` is low. `mnt_done` is a one-cycle pulse that follows the last writeback acknowledge.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted and its address, direction and data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_cmd | input | 2 | Command code |
| req_addr | input | ADDR_W | Word address |
| req_mtype | input | 2 | Memory class of the page |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| rsp_valid | output | 1 | One-cycle completion of a read or write |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_valid on reads |
| probe_valid | input | 1 | Remote-write probe present |
| probe_addr | input | ADDR_W | Address written by another agent |
| probe_ready | output | 1 | Probe accepted this cycle when high with probe_valid |
| mnt_done | output | 1 | One-cycle pulse at the end of a maintenance command |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | DATA_W | Returned read data |

## Verification
The bench targets the points where the classes must be kept apart. A victim that shares an index with a new write must reach memory at its own address, or it is silently lost. A coherent line must reach memory on the write itself and must not be flushed again by a sweep, which would double-count writes. Invalidate-all is checked by changing memory behind the cache: a design that drops the wrong class either returns stale non-coherent data or refetches local data it should keep. The probe cases check the dirty-flush-then-drop order, and they check that a tag mismatch on the same index or a hit on a non-coherent line leaves the line in place.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

    typedef enum logic [1:0] {
        MT_RW = 2'd0,
        MT_CC = 2'd1,
        MT_NC = 2'd2,
        MT_UC = 2'd3
    } mtype_e;

    typedef enum logic [1:0] {
        OP_RD     = 2'd0,
        OP_WR     = 2'd1,
        OP_WBALL  = 2'd2,
        OP_INVALL = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOOK,
        ST_VWB,
        ST_FILL,
        ST_FWAIT,
        ST_WT,
        ST_RESP,
        ST_SWEEP,
        ST_SWB,
        ST_INV,
        ST_PROBE,
        ST_PWB,
        ST_DONE
    } state_e;

endpackage

// File: rtl/mtc_line_store.sv
module mtc_line_store
    import mtc_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [1:0]        rd_mtype,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [1:0]        wr_mtype,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inv_nc
);

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [1:0]        mtype;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    line_t view [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_t line_d, line_q;

        always_comb begin
            line_d = line_q;
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                line_d.valid = wr_valid;
                line_d.dirty = wr_dirty;
                line_d.mtype = wr_mtype;
                line_d.tag   = wr_tag;
                line_d.data  = wr_data;
            end
            if (inv_nc && (line_q.mtype == MT_NC)) begin
                line_d.valid = 1'b0;
                line_d.dirty = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) line_q <= '0;
            else        line_q <= line_d;
        end

        assign view[g] = line_q;
    end

    always_comb begin
        rd_valid = view[rd_idx].valid;
        rd_dirty = view[rd_idx].dirty;
        rd_mtype = view[rd_idx].mtype;
        rd_tag   = view[rd_idx].tag;
        rd_data  = view[rd_idx].data;
    end

endmodule

// File: rtl/mtc_engine.sv
module mtc_engine
    import mtc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_mtype,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              probe_valid,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_ready,
    output logic              mnt_done,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_valid,
    input  logic              rd_dirty,
    input  logic [1:0]        rd_mtype,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              wr_valid,
    output logic              wr_dirty,
    output logic [1:0]        wr_mtype,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data,
    output logic              inv_nc
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    typedef struct packed {
        state_e            st;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        mtype_e            mt;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic [IDX_W-1:0]  cnt;
    } eng_t;

    eng_t r_d, r_q;

    logic [IDX_W-1:0] a_idx;
    logic [TAG_W-1:0] a_tag;
    logic             hit;
    logic             local_class;

    assign a_idx       = r_q.addr[IDX_W-1:0];
    assign a_tag       = r_q.addr[ADDR_W-1:IDX_W];
    assign hit         = rd_valid && (rd_tag == a_tag);
    assign local_class = (rd_mtype == MT_RW) || (rd_mtype == MT_CC);

    always_comb begin
        r_d           = r_q;
        req_ready     = 1'b0;
        probe_ready   = 1'b0;
        rsp_valid     = 1'b0;
        rsp_rdata     = r_q.rdata;
        mnt_done      = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = r_q.addr;
        mem_req_wdata = r_q.wdata;
        inv_nc        = 1'b0;
        rd_idx        = a_idx;
        wr_en         = 1'b0;
        wr_valid      = rd_valid;
        wr_dirty      = rd_dirty;
        wr_mtype      = rd_mtype;
        wr_tag        = rd_tag;
        wr_data       = rd_data;

        case (r_q.st)
            ST_IDLE: begin
                probe_ready = 1'b1;
                req_ready   = !probe_valid;
                if (probe_valid) begin
                    r_d.addr = probe_addr;
                    r_d.st   = ST_PROBE;
                end else if (req_valid) begin
                    r_d.op    = op_e'(req_cmd);
                    r_d.addr  = req_addr;
                    r_d.mt    = mtype_e'(req_mtype);
                    r_d.wdata = req_wdata;
                    r_d.cnt   = '0;
                    case (op_e'(req_cmd))
                        OP_WBALL:  r_d.st = ST_SWEEP;
                        OP_INVALL: r_d.st = ST_INV;
                        default:   r_d.st = ST_LOOK;
                    endcase
                end
            end

            ST_LOOK: begin
                if (r_q.mt == MT_UC) begin
                    r_d.st = (r_q.op == OP_WR) ? ST_WT : ST_FILL;
                end else if (!hit && rd_valid && rd_dirty) begin
                    r_d.st = ST_VWB;
                end else if (r_q.op == OP_RD) begin
                    if (hit) begin
                        r_d.rdata = rd_data;
                        r_d.st    = ST_RESP;
                    end else begin
                        r_d.st = ST_FILL;
                    end
                end else begin
                    wr_en    = 1'b1;
                    wr_valid = 1'b1;
                    wr_dirty = (r_q.mt != MT_CC);
                    wr_mtype = r_q.mt;
                    wr_tag   = a_tag;
                    wr_data  = r_q.wdata;
                    r_d.st   = (r_q.mt == MT_CC) ? ST_WT : ST_RESP;
                end
            end

            ST_VWB: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {rd_tag, a_idx};
                mem_req_wdata = rd_data;
                if (mem_req_ready) begin
                    wr_en    = 1'b1;
                    wr_valid = 1'b0;
                    wr_dirty = 1'b0;
                    r_d.st   = ST_LOOK;
                end
            end

            ST_FILL: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) r_d.st = ST_FWAIT;
            end

            ST_FWAIT: begin
                if (mem_rsp_valid) begin
                    r_d.rdata = mem_rsp_rdata;
                    if (r_q.mt != MT_UC) begin
                        wr_en    = 1'b1;
                        wr_valid = 1'b1;
                        wr_dirty = 1'b0;
                        wr_mtype = r_q.mt;
                        wr_tag   = a_tag;
                        wr_data  = mem_rsp_rdata;
                    end
                    r_d.st = ST_RESP;
                end
            end

            ST_WT: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                if (mem_req_ready) r_d.st = ST_RESP;
            end

            ST_RESP: begin
                rsp_valid = 1'b1;
                r_d.st    = ST_IDLE;
            end

            ST_SWEEP: begin
                rd_idx = r_q.cnt;
                if (rd_valid && rd_dirty) begin
                    r_d.st = ST_SWB;
                end else if (r_q.cnt == LAST_IDX) begin
                    r_d.st = ST_DONE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end

            ST_SWB: begin
                rd_idx        = r_q.cnt;
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {rd_tag, r_q.cnt};
                mem_req_wdata = rd_data;
                if (mem_req_ready) begin
                    wr_en    = 1'b1;
                    wr_dirty = 1'b0;
                    if (r_q.cnt == LAST_IDX) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                        r_d.st  = ST_SWEEP;
                    end
                end
            end

            ST_INV: begin
                inv_nc = 1'b1;
                r_d.st = ST_DONE;
            end

            ST_DONE: begin
                mnt_done = 1'b1;
                r_d.st   = ST_IDLE;
            end

            ST_PROBE: begin
                r_d.st = ST_IDLE;
                if (hit && local_class) begin
                    if (rd_dirty) begin
                        r_d.st = ST_PWB;
                    end else begin
                        wr_en    = 1'b1;
                        wr_valid = 1'b0;
                    end
                end
            end

            ST_PWB: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {rd_tag, a_idx};
                mem_req_wdata = rd_data;
                if (mem_req_ready) begin
                    wr_en    = 1'b1;
                    wr_valid = 1'b0;
                    wr_dirty = 1'b0;
                    r_d.st   = ST_IDLE;
                end
            end

            default: r_d.st = ST_IDLE;
        endcase

        wr_idx = rd_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/mtc_cache_top.sv
module mtc_cache_top
    import mtc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_mtype,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              probe_valid,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_ready,
    output logic              mnt_done,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);

    logic [IDX_W-1:0]  st_ridx;
    logic              st_rvalid;
    logic              st_rdirty;
    logic [1:0]        st_rmtype;
    logic [TAG_W-1:0]  st_rtag;
    logic [DATA_W-1:0] st_rdata;
    logic              st_we;
    logic [IDX_W-1:0]  st_widx;
    logic              st_wvalid;
    logic              st_wdirty;
    logic [1:0]        st_wmtype;
    logic [TAG_W-1:0]  st_wtag;
    logic [DATA_W-1:0] st_wdata;
    logic              st_inv_nc;

    mtc_engine #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LINES  (LINES)
    ) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_cmd       (req_cmd),
        .req_addr      (req_addr),
        .req_mtype     (req_mtype),
        .req_wdata     (req_wdata),
        .req_ready     (req_ready),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .probe_valid   (probe_valid),
        .probe_addr    (probe_addr),
        .probe_ready   (probe_ready),
        .mnt_done      (mnt_done),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata),
        .rd_idx        (st_ridx),
        .rd_valid      (st_rvalid),
        .rd_dirty      (st_rdirty),
        .rd_mtype      (st_rmtype),
        .rd_tag        (st_rtag),
        .rd_data       (st_rdata),
        .wr_en         (st_we),
        .wr_idx        (st_widx),
        .wr_valid      (st_wvalid),
        .wr_dirty      (st_wdirty),
        .wr_mtype      (st_wmtype),
        .wr_tag        (st_wtag),
        .wr_data       (st_wdata),
        .inv_nc        (st_inv_nc)
    );

    mtc_line_store #(
        .LINES  (LINES),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (st_ridx),
        .rd_valid (st_rvalid),
        .rd_dirty (st_rdirty),
        .rd_mtype (st_rmtype),
        .rd_tag   (st_rtag),
        .rd_data  (st_rdata),
        .wr_en    (st_we),
        .wr_idx   (st_widx),
        .wr_valid (st_wvalid),
        .wr_dirty (st_wdirty),
        .wr_mtype (st_wmtype),
        .wr_tag   (st_wtag),
        .wr_data  (st_wdata),
        .inv_nc   (st_inv_nc)
    );

endmodule

// File: rtl/mtc_cache_chk.sv
module mtc_cache_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_cmd,
    input logic              rsp_valid,
    input logic              mnt_done,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata,
    input logic              st_we,
    input logic              st_wvalid,
    input logic              st_wdirty,
    input logic [1:0]        st_wmtype
);

    logic maint_pend;

    always_ff @(posedge clk) begin
        if (!rst_n)                                       maint_pend <= 1'b0;
        else if (req_valid && req_ready && req_cmd[1])    maint_pend <= 1'b1;
        else if (mnt_done)                                maint_pend <= 1'b0;
    end

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                              // R2

    AST_UC_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && st_wvalid) |-> (st_wmtype != 2'd3));                          // R3

    AST_CC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && st_wvalid && st_wmtype == 2'd1) |-> !st_wdirty);              // R4

    AST_DIRTY_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && st_wdirty) |-> (st_wmtype == 2'd0 || st_wmtype == 2'd2));     // R5

    AST_DONE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        mnt_done |-> maint_pend);                                               // R6

    AST_MAINT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        maint_pend |-> !req_ready);                                             // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mnt_done |=> !mnt_done);                                                // R9

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && $stable(mem_req_wdata)));                                       // R10

endmodule

bind mtc_cache_top mtc_cache_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_cmd       (req_cmd),
    .rsp_valid     (rsp_valid),
    .mnt_done      (mnt_done),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .st_we         (st_we),
    .st_wvalid     (st_wvalid),
    .st_wdirty     (st_wdirty),
    .st_wmtype     (st_wmtype)
);

// File: tb/tb_mtc_cache_top.sv
module tb_mtc_cache_top;
    import mtc_pkg::*;

    localparam int AW = 12;
    localparam int DW = 32;

    localparam logic [AW-1:0] A_RD = 12'h010;
    localparam logic [AW-1:0] A_UC = 12'h023;
    localparam logic [AW-1:0] A_CC = 12'h032;
    localparam logic [AW-1:0] A_W1 = 12'h045;
    localparam logic [AW-1:0] A_W2 = 12'h055;
    localparam logic [AW-1:0] A_NC = 12'h067;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_cmd = '0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_mtype = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          probe_valid = 1'b0;
    logic [AW-1:0] probe_addr = '0;
    logic          probe_ready;
    logic          mnt_done;
    logic          mem_req_valid;
    logic          mem_req_ready;
    logic          mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_rsp_valid;
    logic [DW-1:0] mem_rsp_rdata;

    always #5 clk = ~clk;

    mtc_cache_top dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_cmd       (req_cmd),
        .req_addr      (req_addr),
        .req_mtype     (req_mtype),
        .req_wdata     (req_wdata),
        .req_ready     (req_ready),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .probe_valid   (probe_valid),
        .probe_addr    (probe_addr),
        .probe_ready   (probe_ready),
        .mnt_done      (mnt_done),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata)
    );

    // memory model with stalls and a side door for other agents
    logic [DW-1:0] mem [1 << AW];
    logic [2:0]    rdy_cnt;
    int            rd_cnt, wr_cnt;
    logic          bd_we = 1'b0;
    logic [AW-1:0] bd_addr = '0;
    logic [DW-1:0] bd_data = '0;

    function automatic logic [DW-1:0] init_val(input int a);
        return 32'hC0DE_0000 | DW'(a);
    endfunction

    assign mem_req_ready = (rdy_cnt[1:0] != 2'b01);

    always_ff @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (!rst_n) begin
            rdy_cnt <= '0;
            rd_cnt  <= 0;
            wr_cnt  <= 0;
            mem_rsp_rdata <= '0;
            for (int i = 0; i < (1 << AW); i++) mem[i] <= init_val(i);
        end else begin
            rdy_cnt <= rdy_cnt + 1'b1;
            if (bd_we) mem[bd_addr] <= bd_data;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    mem[mem_req_addr] <= mem_req_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_rdata <= mem[mem_req_addr];
                    rd_cnt <= rd_cnt + 1;
                end
            end
        end
    end

    // handshake stability monitor
    logic          pv_stall;
    logic          pv_write;
    logic [AW-1:0] pv_addr;
    logic [DW-1:0] pv_data;
    int            stall_seen, stall_bad;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_stall <= 1'b0; pv_write <= 1'b0; pv_addr <= '0; pv_data <= '0;
            stall_seen <= 0; stall_bad <= 0;
        end else begin
            pv_stall <= mem_req_valid && !mem_req_ready;
            pv_write <= mem_req_write;
            pv_addr  <= mem_req_addr;
            pv_data  <= mem_req_wdata;
            if (mem_req_valid && !mem_req_ready) stall_seen <= stall_seen + 1;
            if (pv_stall && (!mem_req_valid || mem_req_write != pv_write ||
                             mem_req_addr != pv_addr ||
                             (pv_write && mem_req_wdata != pv_data)))
                stall_bad <= stall_bad + 1;
        end
    end

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] cmd, input logic [AW-1:0] a,
                        input logic [1:0] mt, input logic [DW-1:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_addr = a; req_mtype = mt; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic access(input logic [1:0] cmd, input logic [AW-1:0] a,
                          input logic [1:0] mt, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rdata);
        send(cmd, a, mt, wd);
        while (!rsp_valid) @(negedge clk);
        rdata = rsp_rdata;
    endtask

    task automatic maint(input logic [1:0] cmd, output bit stalled_ok);
        send(cmd, '0, '0, '0);
        stalled_ok = 1'b1;
        while (!mnt_done) begin
            if (req_ready) stalled_ok = 1'b0;
            @(negedge clk);
        end
        if (req_ready) stalled_ok = 1'b0;
    endtask

    task automatic probe(input logic [AW-1:0] a);
        @(negedge clk);
        probe_valid = 1'b1; probe_addr = a;
        while (!probe_ready) @(negedge clk);
        @(negedge clk);
        probe_valid = 1'b0;
        while (!req_ready) @(negedge clk);
    endtask

    task automatic backdoor(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bd_we = 1'b1; bd_addr = a; bd_data = d;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic t_reset;
        chk(req_ready === 1'b1,     "R1 req_ready",     DW'(req_ready),     1);
        chk(probe_ready === 1'b1,   "R1 probe_ready",   DW'(probe_ready),   1);
        chk(rsp_valid === 1'b0,     "R1 rsp_valid",     DW'(rsp_valid),     0);
        chk(mnt_done === 1'b0,      "R1 mnt_done",      DW'(mnt_done),      0);
        chk(mem_req_valid === 1'b0, "R1 mem_req_valid", DW'(mem_req_valid), 0);
    endtask

    task automatic t_fill;
        logic [DW-1:0] d; int r0;
        r0 = rd_cnt;
        access(OP_RD, A_RD, MT_RW, '0, d);
        chk(d == init_val(int'(A_RD)), "R2 miss data", d, init_val(int'(A_RD)));
        chk(rd_cnt == r0 + 1, "R2 miss fetch count", DW'(rd_cnt - r0), 1);
        r0 = rd_cnt;
        access(OP_RD, A_RD, MT_RW, '0, d);
        chk(d == init_val(int'(A_RD)), "R2 hit data", d, init_val(int'(A_RD)));
        chk(rd_cnt == r0, "R2 hit no fetch", DW'(rd_cnt - r0), 0);
    endtask

    task automatic t_uncached;
        logic [DW-1:0] d; int r0, w0;
        r0 = rd_cnt;
        access(OP_RD, A_UC, MT_UC, '0, d);
        access(OP_RD, A_UC, MT_UC, '0, d);
        chk(rd_cnt == r0 + 2, "R3 uncached reads both fetch", DW'(rd_cnt - r0), 2);
        chk(d == init_val(int'(A_UC)), "R3 uncached read data", d, init_val(int'(A_UC)));
        w0 = wr_cnt;
        access(OP_WR, A_UC, MT_UC, 32'h1111_2222, d);
        chk(wr_cnt == w0 + 1, "R3 uncached write count", DW'(wr_cnt - w0), 1);
        chk(mem[A_UC] == 32'h1111_2222, "R3 uncached write data", mem[A_UC], 32'h1111_2222);
        r0 = rd_cnt;
        access(OP_RD, A_UC, MT_UC, '0, d);
        chk(d == 32'h1111_2222 && rd_cnt == r0 + 1, "R3 uncached read after write",
            d, 32'h1111_2222);
    endtask

    task automatic t_coherent;
        logic [DW-1:0] d; int r0, w0;
        w0 = wr_cnt;
        access(OP_WR, A_CC, MT_CC, 32'hCCCC_0001, d);
        chk(wr_cnt == w0 + 1, "R4 write-through count", DW'(wr_cnt - w0), 1);
        chk(mem[A_CC] == 32'hCCCC_0001, "R4 write-through data", mem[A_CC], 32'hCCCC_0001);
        r0 = rd_cnt;
        access(OP_RD, A_CC, MT_CC, '0, d);
        chk(d == 32'hCCCC_0001 && rd_cnt == r0, "R4 coherent line allocated", d, 32'hCCCC_0001);
    endtask

    task automatic t_local_dirty;
        logic [DW-1:0] d; int r0, w0;
        w0 = wr_cnt; r0 = rd_cnt;
        access(OP_WR, A_W1, MT_RW, 32'hAAAA_0001, d);
        chk(wr_cnt == w0 && rd_cnt == r0, "R5 rw write no traffic",
            DW'(wr_cnt - w0 + rd_cnt - r0), 0);
        chk(mem[A_W1] == init_val(int'(A_W1)), "R5 rw memory untouched",
            mem[A_W1], init_val(int'(A_W1)));
        access(OP_RD, A_W1, MT_RW, '0, d);
        chk(d == 32'hAAAA_0001 && rd_cnt == r0, "R5 rw read back", d, 32'hAAAA_0001);
        w0 = wr_cnt;
        access(OP_WR, A_NC, MT_NC, 32'hBBBB_0001, d);
        chk(wr_cnt == w0 && rd_cnt == r0, "R5 nc write no traffic",
            DW'(wr_cnt - w0 + rd_cnt - r0), 0);
    endtask

    task automatic t_victim;
        logic [DW-1:0] d; int r0, w0;
        w0 = wr_cnt; r0 = rd_cnt;
        access(OP_WR, A_W2, MT_RW, 32'hAAAA_0002, d);
        chk(wr_cnt == w0 + 1, "R5 victim writeback count", DW'(wr_cnt - w0), 1);
        chk(mem[A_W1] == 32'hAAAA_0001, "R5 victim data at own address",
            mem[A_W1], 32'hAAAA_0001);
        chk(rd_cnt == r0, "R5 write miss no fill", DW'(rd_cnt - r0), 0);
    endtask

    task automatic t_wball;
        bit ok; int w0;
        w0 = wr_cnt;
        maint(OP_WBALL, ok);
        chk(ok, "R9 ready low during writeback-all", DW'(ok), 1);
        chk(wr_cnt == w0 + 2, "R6 writeback-all count", DW'(wr_cnt - w0), 2);
        chk(mem[A_W2] == 32'hAAAA_0002, "R6 rw line flushed", mem[A_W2], 32'hAAAA_0002);
        chk(mem[A_NC] == 32'hBBBB_0001, "R6 nc line flushed", mem[A_NC], 32'hBBBB_0001);
        @(negedge clk);
        chk(mnt_done === 1'b0, "R9 done one cycle", DW'(mnt_done), 0);
        w0 = wr_cnt;
        maint(OP_WBALL, ok);
        chk(wr_cnt == w0, "R6 second sweep silent (R4 coherent not flushed)",
            DW'(wr_cnt - w0), 0);
    endtask

    task automatic t_invall;
        logic [DW-1:0] d; bit ok; int r0, w0;
        backdoor(A_NC, 32'h5555_0001);
        backdoor(A_CC, 32'h5555_0002);
        backdoor(A_W2, 32'h5555_0003);
        r0 = rd_cnt; w0 = wr_cnt;
        maint(OP_INVALL, ok);
        chk(ok && wr_cnt == w0 && rd_cnt == r0, "R7 invalidate-all no traffic",
            DW'(wr_cnt - w0 + rd_cnt - r0), 0);
        access(OP_RD, A_NC, MT_NC, '0, d);
        chk(d == 32'h5555_0001 && rd_cnt == r0 + 1, "R7 nc refetched", d, 32'h5555_0001);
        r0 = rd_cnt;
        access(OP_RD, A_W2, MT_RW, '0, d);
        chk(d == 32'hAAAA_0002 && rd_cnt == r0, "R7 rw kept", d, 32'hAAAA_0002);
        access(OP_RD, A_CC, MT_CC, '0, d);
        chk(d == 32'hCCCC_0001 && rd_cnt == r0, "R7 cc kept", d, 32'hCCCC_0001);
    endtask

    task automatic t_probe;
        logic [DW-1:0] d; int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        probe(12'h0A2);
        access(OP_RD, A_CC, MT_CC, '0, d);
        chk(d == 32'hCCCC_0001 && rd_cnt == r0 && wr_cnt == w0,
            "R8 tag mismatch probe ignored", d, 32'hCCCC_0001);
        access(OP_WR, A_W2, MT_RW, 32'hAAAA_0003, d);
        w0 = wr_cnt;
        probe(A_W2);
        chk(wr_cnt == w0 + 1 && mem[A_W2] == 32'hAAAA_0003, "R8 dirty probe flush",
            mem[A_W2], 32'hAAAA_0003);
        r0 = rd_cnt;
        access(OP_RD, A_W2, MT_RW, '0, d);
        chk(d == 32'hAAAA_0003 && rd_cnt == r0 + 1, "R8 rw refetch after probe",
            d, 32'hAAAA_0003);
        w0 = wr_cnt;
        probe(A_CC);
        r0 = rd_cnt;
        access(OP_RD, A_CC, MT_CC, '0, d);
        chk(d == 32'h5555_0002 && rd_cnt == r0 + 1 && wr_cnt == w0,
            "R8 cc probe invalidates", d, 32'h5555_0002);
        backdoor(A_NC, 32'h5555_0009);
        probe(A_NC);
        r0 = rd_cnt;
        access(OP_RD, A_NC, MT_NC, '0, d);
        chk(d == 32'h5555_0001 && rd_cnt == r0, "R8 nc probe ignored", d, 32'h5555_0001);
    endtask

    task automatic t_handshake;
        chk(stall_seen > 0, "R10 stalls exercised", DW'(stall_seen), 1);
        chk(stall_bad == 0, "R10 request held while stalled", DW'(stall_bad), 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_uncached();
        t_coherent();
        t_local_dirty();
        t_victim();
        t_wball();
        t_invall();
        t_probe();
        t_handshake();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

endmodule